// File: doc/BRIEF.md
# Serial Receive Channel with Flagged Holding Queue

This block is one asynchronous serial receiver. A 16X sample-clock enable paces it. It finds and qualifies start bits on the serial input and assembles characters of five to eight data bits, with an optional parity bit. Each finished character goes into a three-deep holding queue, and its own parity, framing and break flags travel with it.

The CPU side sees two things. The first is a read-data port that always presents the oldest character; a one-cycle pop strobe advances the queue. The second is a set of status outputs. These give ready, full, overrun and the three error flags, and an error-clear strobe resets the sticky status.

The error flags are reported in one of two ways. In per-character mode they belong to the character at the head of the queue. In accumulate mode they are the OR of every character that has reached the head since the last error-clear.

When the queue is full, a newly completed character is not dropped. It waits in the assembly register until a slot frees up. If another start bit is qualified while it waits, the waiting character is lost and overrun is flagged.

Top module: `serial_rx_channel`

## Requirements
- R1: The serial input passes through a two-flop synchronizer. A start is detected on a high-to-low change seen on a sample tick, and the line is sampled again 8 ticks after detection. If the line is high at that point, the start is rejected and no character is produced.
- R2: Data bits are sampled every 16 ticks after the qualified start, least significant bit first. `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper bits of `rd_data` read as zero.
- R3: After reset the queue is empty and all status outputs are 0. The queue holds three characters. `st_ready` is 1 while at least one character is held, and `st_full` is 1 while three are held.
- R4: `cfg_par` selects the parity: 0 none, 1 even, 2 odd, 3 forced to the level of `cfg_force`. A received parity bit that differs from the expected one sets the character's parity flag.
- R5: In per-character mode (`cfg_block`=0) the error outputs show the flags of the head character, and they are 0 when the queue is empty.
- R6: In accumulate mode (`cfg_block`=1) the error outputs hold the OR of the flags of all characters that reached the head since the last `err_clr`. `err_clr` clears that accumulation and the overrun flag.
- R7: Status outputs and `rd_data` may be observed any number of times without changing the queue. Only `rd_pop` removes the head, and a pop of an empty queue has no effect.
- R8: A character that completes while the queue is full waits and enters the queue after the next pop, keeping its order. If a further start is qualified while it waits, that character is discarded and `st_overrun` is set.
- R9: If the line stays low through all data bits, the parity bit and the stop bit, the stored character is all zero with the break and framing flags set. No further character is assembled until the line has returned high.
- R10: A nonzero character whose stop bit is low sets the framing flag. If the line is still low 8 ticks after the stop sample, that point is taken as a newly detected start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length code (5 + value bits) |
| cfg_par | input | 2 | Parity mode: none, even, odd, forced |
| cfg_force | input | 1 | Parity level used in forced mode |
| cfg_block | input | 1 | 1 = accumulate error flags, 0 = per character |
| rd_pop | input | 1 | Removes the head character |
| err_clr | input | 1 | Clears overrun and accumulated flags |
| rd_data | output | 8 | Head character, zero when empty |
| st_ready | output | 1 | At least one character held |
| st_full | output | 1 | Queue holds three characters |
| st_overrun | output | 1 | A waiting character was lost |
| st_perr | output | 1 | Parity error status |
| st_ferr | output | 1 | Framing error status |
| st_brk | output | 1 | Received-break status |

## Verification
The serial input reaches the sampling logic two cycles late through the synchronizer. A stop bit is therefore sampled ten ticks into its slot, and the character is in the queue two cycles after that. The bench holds the tick high and idles the line for six cycles after each stop slot before it looks at `rd_data` and the flags. A pop changes the head at the next edge, and a waiting character moves into the queue one edge after that. So the bench checks the head one negative edge after a pop and checks `st_full` two edges after it. All outputs are sampled on falling edges, away from the edges where they change.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FORCE = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_FRGAP,
        ST_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
    } rx_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        rx_flags_t         flags;
    } rx_entry_t;

    function automatic logic expected_parity(input par_mode_e mode,
                                             input logic [DATA_W-1:0] d,
                                             input logic force_lvl);
        case (mode)
            PAR_EVEN:  return ^d;
            PAR_ODD:   return ~^d;
            PAR_FORCE: return force_lvl;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer import srx_pkg::*; #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  par_mode_e  cfg_par,
    input  logic       cfg_force,
    output logic       done,
    output rx_entry_t  entry,
    output logic       start_ok
);
    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam logic [CW-1:0] LAST_T = CW'(TICKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_T = CW'(TICKS_PER_BIT / 2 - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              armed;

    logic [2:0] last_idx;
    logic       par_en;
    logic       is_brk;
    logic       par_bad;

    always_comb begin
        last_idx = 3'd4 + {1'b0, cfg_len};
        par_en   = (cfg_par != PAR_NONE);
        is_brk   = (shreg == '0) && !(par_en && par_bit) && !rxd;
        par_bad  = par_en && (par_bit != expected_parity(cfg_par, shreg, cfg_force));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            armed    <= 1'b1;
            done     <= 1'b0;
            start_ok <= 1'b0;
            entry    <= '0;
        end else begin
            done     <= 1'b0;
            start_ok <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        armed <= rxd;
                        if (armed && !rxd) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF_T) begin
                            cnt <= '0;
                            if (rxd) begin
                                state <= ST_IDLE;
                                armed <= 1'b1;
                            end else begin
                                state    <= ST_DATA;
                                bit_idx  <= '0;
                                shreg    <= '0;
                                par_bit  <= 1'b0;
                                start_ok <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST_T) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= rxd;
                            if (bit_idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == LAST_T) begin
                            cnt     <= '0;
                            par_bit <= rxd;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST_T) begin
                            cnt              <= '0;
                            done             <= 1'b1;
                            entry.data       <= is_brk ? '0 : shreg;
                            entry.flags.brk  <= is_brk;
                            entry.flags.ferr <= !rxd;
                            entry.flags.perr <= par_bad && !is_brk;
                            if (rxd) begin
                                state <= ST_IDLE;
                                armed <= 1'b1;
                            end else if (is_brk || shreg == '0) begin
                                state <= ST_WAITHI;
                            end else begin
                                state <= ST_FRGAP;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_FRGAP: begin
                        if (cnt == HALF_T) begin
                            cnt <= '0;
                            if (rxd) begin
                                state <= ST_IDLE;
                                armed <= 1'b1;
                            end else begin
                                state <= ST_START;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAITHI: begin
                        if (rxd) begin
                            state <= ST_IDLE;
                            armed <= 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo import srx_pkg::*; #(
    parameter int DEPTH  = 3,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  rx_entry_t         wr_entry,
    input  logic              pop,
    output rx_entry_t         head,
    output logic [FILL_W-1:0] fill,
    output logic              empty,
    output logic              full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0]     PTR_LAST = PW'(DEPTH - 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic          do_pop;
    logic          do_push;

    assign empty   = (fill == '0);
    assign full    = (fill == FILL_MAX);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_entry;
    end
endmodule

// File: rtl/srx_status.sv
module srx_status import srx_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      block_mode,
    input  logic      err_clr,
    input  logic      head_valid,
    input  rx_flags_t head_flags,
    input  logic      pop,
    input  logic      ovr_evt,
    output rx_flags_t shown,
    output logic      overrun
);
    rx_flags_t acc_q;
    rx_flags_t fresh_f;
    logic      seen_q;

    assign fresh_f = (head_valid && !seen_q) ? head_flags : rx_flags_t'('0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            seen_q  <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (err_clr) acc_q <= fresh_f;
            else         acc_q <= rx_flags_t'(acc_q | fresh_f);

            if (pop && head_valid) seen_q <= 1'b0;
            else if (head_valid)   seen_q <= 1'b1;

            if (err_clr)      overrun <= 1'b0;
            else if (ovr_evt) overrun <= 1'b1;
        end
    end

    always_comb begin
        if (block_mode)      shown = rx_flags_t'(acc_q | fresh_f);
        else if (head_valid) shown = head_flags;
        else                 shown = '0;
    end
endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel import srx_pkg::*; #(
    parameter int TICKS_PER_BIT = 16,
    parameter int DEPTH         = 3,
    parameter int SYNC_STAGES   = 2,
    parameter int FILL_W        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_force,
    input  logic              cfg_block,
    input  logic              rd_pop,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              st_ready,
    output logic              st_full,
    output logic              st_overrun,
    output logic              st_perr,
    output logic              st_ferr,
    output logic              st_brk
);
    logic              rxd_s;
    logic              done;
    logic              start_ok;
    rx_entry_t         new_entry;
    rx_entry_t         hold_q;
    logic              hold_v;
    logic              push;
    rx_entry_t         push_entry;
    rx_entry_t         head;
    logic [FILL_W-1:0] fill_cnt;
    logic              empty;
    logic              full;
    logic              ovr_evt;
    rx_flags_t         shown;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rxd_s)
    );

    srx_framer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .rxd       (rxd_s),
        .cfg_len   (cfg_len),
        .cfg_par   (par_mode_e'(cfg_par)),
        .cfg_force (cfg_force),
        .done      (done),
        .entry     (new_entry),
        .start_ok  (start_ok)
    );

    // A waiting character has precedence; a fresh one goes in only when nothing waits.
    always_comb begin
        push       = 1'b0;
        push_entry = new_entry;
        if (hold_v && !full) begin
            push       = 1'b1;
            push_entry = hold_q;
        end else if (done && !hold_v && !full) begin
            push = 1'b1;
        end
    end

    assign ovr_evt = start_ok && hold_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else begin
            if (ovr_evt || (hold_v && !full)) hold_v <= 1'b0;
            if (done && full) begin
                hold_v <= 1'b1;
                hold_q <= new_entry;
            end
        end
    end

    srx_fifo #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wr_entry (push_entry),
        .pop      (rd_pop),
        .head     (head),
        .fill     (fill_cnt),
        .empty    (empty),
        .full     (full)
    );

    srx_status u_status (
        .clk        (clk),
        .rst        (rst),
        .block_mode (cfg_block),
        .err_clr    (err_clr),
        .head_valid (!empty),
        .head_flags (head.flags),
        .pop        (rd_pop),
        .ovr_evt    (ovr_evt),
        .shown      (shown),
        .overrun    (st_overrun)
    );

    assign rd_data  = empty ? '0 : head.data;
    assign st_ready = !empty;
    assign st_full  = full;
    assign st_perr  = shown.perr;
    assign st_ferr  = shown.ferr;
    assign st_brk   = shown.brk;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DEPTH  = 3,
    parameter int FILL_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_block,
    input logic              rd_pop,
    input logic              err_clr,
    input logic [7:0]        rd_data,
    input logic              st_ready,
    input logic              st_full,
    input logic              st_overrun,
    input logic              st_perr,
    input logic              st_ferr,
    input logic              st_brk,
    input logic [FILL_W-1:0] fill
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(DEPTH)) else $error("fill above depth"); // R3

    AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (rst)
        st_full |-> st_ready) else $error("full without ready"); // R3

    AST_EMPTY_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (!cfg_block && !st_ready) |-> !(st_perr || st_ferr || st_brk)) else $error("flags while empty"); // R5

    AST_NO_POP_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
        (st_ready && !rd_pop) |=> st_ready) else $error("entry lost without pop"); // R7

    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (st_full && !rd_pop) |=> st_full) else $error("full dropped without pop"); // R8

    AST_CLR_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> !st_overrun) else $error("overrun survived clear"); // R6

    AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st_brk && !cfg_block) |-> (rd_data == 8'h00)) else $error("break char nonzero"); // R9
endmodule

bind serial_rx_channel srx_checker #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_block  (cfg_block),
    .rd_pop     (rd_pop),
    .err_clr    (err_clr),
    .rd_data    (rd_data),
    .st_ready   (st_ready),
    .st_full    (st_full),
    .st_overrun (st_overrun),
    .st_perr    (st_perr),
    .st_ferr    (st_ferr),
    .st_brk     (st_brk),
    .fill       (fill_cnt)
);

// File: tb/tb_serial_rx_channel.sv
module tb_serial_rx_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_force = 1'b0;
    logic       cfg_block = 1'b0;
    logic       rd_pop = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rd_data;
    logic       st_ready, st_full, st_overrun, st_perr, st_ferr, st_brk;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    serial_rx_channel dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_force(cfg_force),
        .cfg_block(cfg_block), .rd_pop(rd_pop), .err_clr(err_clr),
        .rd_data(rd_data), .st_ready(st_ready), .st_full(st_full),
        .st_overrun(st_overrun), .st_perr(st_perr), .st_ferr(st_ferr),
        .st_brk(st_brk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic slot(input logic lvl);
        rxd = lvl;
        repeat (16) @(negedge clk);
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] len);
        return 8'hFF >> (3 - len);
    endfunction

    function automatic logic par_of(input logic [7:0] d);
        case (cfg_par)
            2'd1:    return ^d;
            2'd2:    return ~^d;
            2'd3:    return cfg_force;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_char(input logic [7:0] d, input logic bad_par, input logic stop_lvl);
        logic [7:0] m;
        m = d & mask_of(cfg_len);
        slot(1'b0);
        for (int i = 0; i < 5 + int'(cfg_len); i++) slot(m[i]);
        if (cfg_par != 2'd0) slot(par_of(m) ^ bad_par);
        slot(stop_lvl);
        idle(6);
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] vals [4];
        vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'hFF; vals[3] = 8'h01;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(4);

        // R3 reset state
        chk("R3 reset ready", st_ready, 0);
        chk("R3 reset full", st_full, 0);
        chk("R3 reset flags", {st_overrun, st_perr, st_ferr, st_brk}, 0);
        chk("R3 reset data", rd_data, 0);

        // R2 R4 sweep: every length, every parity mode, several patterns
        for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 4; p++) begin
                for (int v = 0; v < 4; v++) begin
                    cfg_len   = 2'(l);
                    cfg_par   = 2'(p);
                    cfg_force = v[0];
                    send_char(vals[v], 1'b0, 1'b1);
                    chk("R2 data", rd_data, vals[v] & mask_of(2'(l)));
                    chk("R4 clean flags", {st_perr, st_ferr, st_brk}, 0);
                    pop_one();
                    chk("R3 empty after pop", st_ready, 0);
                end
            end
        end

        // R4 parity mismatch in each parity mode
        cfg_len = 2'd3;
        for (int p = 1; p < 4; p++) begin
            cfg_par = 2'(p);
            cfg_force = 1'b1;
            send_char(8'h5A, 1'b1, 1'b1);
            chk("R4 parity flag", {st_perr, st_ferr, st_brk}, 3'b100);
            chk("R4 data kept", rd_data, 8'h5A);
            pop_one();
        end
        cfg_par = 2'd0;

        // R1 short low pulse rejected
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        idle(40);
        chk("R1 false start rejected", st_ready, 0);

        // R10 framing with line going high at once
        send_char(8'h81, 1'b0, 1'b0);
        chk("R10 framing flag", {st_perr, st_ferr, st_brk}, 3'b010);
        chk("R10 framing data", rd_data, 8'h81);
        pop_one();
        idle(20);
        chk("R10 no extra char", st_ready, 0);

        // R10 line still low after stop: restart point
        slot(1'b0);
        for (int i = 0; i < 8; i++) slot(i[0] ? 1'b0 : 1'b1);
        slot(1'b0);
        slot(1'b0);
        for (int i = 0; i < 8; i++) slot(1'b1);
        slot(1'b1);
        idle(6);
        chk("R10 first char", rd_data, 8'h55);
        chk("R10 first ferr", st_ferr, 1);
        pop_one();
        chk("R10 restarted char", rd_data, 8'hFF);
        chk("R10 restarted flags", {st_perr, st_ferr, st_brk}, 0);
        pop_one();

        // R9 break
        for (int i = 0; i < 12; i++) slot(1'b0);
        idle(30);
        chk("R9 break stored", st_ready, 1);
        chk("R9 break data", rd_data, 0);
        chk("R9 break flags", {st_perr, st_ferr, st_brk}, 3'b011);
        pop_one();
        chk("R9 single entry", st_ready, 0);

        // R3 R7 R8 fill, wait, overrun
        send_char(8'h11, 1'b0, 1'b1);
        send_char(8'h22, 1'b0, 1'b1);
        send_char(8'h33, 1'b0, 1'b1);
        chk("R3 full", st_full, 1);
        send_char(8'h44, 1'b0, 1'b1);
        chk("R8 waiting no overrun", st_overrun, 0);
        chk("R7 head stable", rd_data, 8'h11);
        chk("R7 head stable again", rd_data, 8'h11);
        pop_one();
        @(negedge clk);
        chk("R8 waiting char entered", st_full, 1);
        chk("R8 order", rd_data, 8'h22);
        send_char(8'h55, 1'b0, 1'b1);
        send_char(8'h66, 1'b0, 1'b1);
        chk("R8 overrun set", st_overrun, 1);
        pop_one(); @(negedge clk);
        chk("R8 read 33", rd_data, 8'h33);
        pop_one(); @(negedge clk);
        chk("R8 read 44", rd_data, 8'h44);
        pop_one(); @(negedge clk);
        chk("R8 read 66 after drop", rd_data, 8'h66);
        pop_one(); @(negedge clk);
        chk("R8 drained", st_ready, 0);
        pop_one();
        chk("R7 pop of empty", {st_ready, st_full}, 0);
        chk("R8 overrun sticky", st_overrun, 1);
        clear_err();
        chk("R6 clear overrun", st_overrun, 0);

        // R5 per-character mode
        cfg_par = 2'd1;
        send_char(8'h0F, 1'b1, 1'b1);
        send_char(8'h0E, 1'b0, 1'b1);
        chk("R5 head parity", st_perr, 1);
        pop_one();
        chk("R5 next head clean", st_perr, 0);
        pop_one();

        // R6 accumulate mode
        cfg_block = 1'b1;
        clear_err();
        send_char(8'h0F, 1'b1, 1'b1);
        send_char(8'h0E, 1'b0, 1'b1);
        chk("R6 parity seen", st_perr, 1);
        pop_one();
        chk("R6 parity sticky", st_perr, 1);
        clear_err();
        chk("R6 cleared", st_perr, 0);
        pop_one();
        chk("R6 stays clear", {st_perr, st_ferr, st_brk}, 0);
        cfg_block = 1'b0;

        finish_run();
    end
endmodule